// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor core that finishes each instruction in one clock cycle. It supports seven instructions: add unsigned, subtract unsigned, OR with a zero-extended immediate, load word, store word, branch when two registers are equal, and an absolute jump. The datapath has these parts:

- a register file of 32 words, 32 bits each;
- an immediate extender that can zero-extend or sign-extend;
- a three-function ALU;
- a word-addressed data memory;
- an instruction memory;
- a main decoder that produces every control point.

In the same rising edge, the core loads the program counter, writes the register file and writes the data memory. Register reads and memory reads are combinational.

The instruction memory is loaded through a program-write port. The core is normally held in reset while this happens. A debug read port on the register file and the program counter output let the surroundings observe the architectural state. No exceptions are raised. Any encoding the decoder does not recognise updates no register and no memory word, and the core then moves on to the next instruction.

Instruction fields use fixed positions:

| Format | Fields |
|--------|--------|
| All | op[31:26] |
| Register form | rs[25:21], rt[20:16], rd[15:11], function code[5:0] |
| Immediate form | rs, rt, imm16[15:0] |
| Jump form | target[25:0] |

Top module: `sc_core`

## Requirements
- R1: While rst_n is low, every rising edge sets the PC to 0 and every register to 0. Reset is synchronous and active low.
- R2: Opcode 0x00 with function code 0x21 writes R[rs]+R[rt] into R[rd]. Opcode 0x00 with function code 0x23 writes R[rs]-R[rt] into R[rd]. Both results wrap modulo 2^32.
- R3: Opcode 0x0D writes R[rs] OR {16'b0, imm16} into R[rt].
- R4: For both memory instructions, the address is R[rs] + sign_ext(imm16), and the data word is selected by bits [log2(DMEM_WORDS)+1:2] of that address. Opcode 0x23 (load) writes the addressed word into R[rt]. Opcode 0x2B (store) writes R[rt] into the addressed word and leaves every register unchanged.
- R5: Opcode 0x04 sets the next PC to PC+4+(sign_ext(imm16)<<2) when R[rs]==R[rt], and to PC+4 otherwise.
- R6: Opcode 0x02 sets the next PC to {PC+4 bits [31:28], target, 2'b00}.
- R7: Register 0 always reads as 0, and writes addressed to it have no effect.
- R8: For any other opcode, or opcode 0x00 with any other function code, no register and no memory word is written, and the PC advances by 4.
- R9: A register or memory write made by one instruction is visible to the next instruction. Reads are combinational, and writes take effect on the same edge that advances the PC.
- R10: Every instruction other than a taken branch or a jump advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Write enable for the instruction memory |
| prog_addr | input | log2(IMEM_WORDS) | Word index written when prog_we is high |
| prog_data | input | 32 | Instruction word to store |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Combinational value of register dbg_sel |
| pc | output | 32 | Current program counter (byte address) |

## Verification
Every result in this core appears one rising edge after the instruction that produces it. The PC step, the register write and the memory write all land on that edge, and the next instruction sees them through combinational reads. The bench therefore loads a program under reset, releases reset at a falling edge, and checks the PC at each following falling edge against an execution trace it works out from the program's branch and jump offsets. Register contents are read through the combinational debug port only after the program has reached its self-loop. Each expected value is computed with ordinary 32-bit arithmetic on the immediates the bench placed in the program.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_JMP  = 6'h02;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUBU = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_fn_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    imm_signed;
    alu_fn_e alu_fn;
    logic    wb_from_mem;
    logic    reg_wr;
    logic    mem_wr;
    logic    branch;
    logic    jump;
  } ctrl_t;

  function automatic logic [XLEN-1:0] alu_calc(alu_fn_e fn, logic [XLEN-1:0] a,
                                               logic [XLEN-1:0] b);
    case (fn)
      ALU_SUB: return a - b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] widen_imm(logic [15:0] imm, logic signed_mode);
    return {{(XLEN-16){signed_mode & imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(logic [XLEN-1:0] pc_next_seq,
                                                  logic [XLEN-1:0] imm_wide);
    return pc_next_seq + {imm_wide[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(logic [XLEN-1:0] pc_next_seq,
                                                logic [25:0] tgt);
    return {pc_next_seq[XLEN-1:28], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output logic       unknown
);

  always_comb begin
    ctrl    = '0;
    unknown = 1'b0;
    case (opcode)
      OP_REG: begin
        ctrl.dst_is_rd = 1'b1;
        if (funct == FN_ADDU) begin
          ctrl.reg_wr = 1'b1;
          ctrl.alu_fn = ALU_ADD;
        end else if (funct == FN_SUBU) begin
          ctrl.reg_wr = 1'b1;
          ctrl.alu_fn = ALU_SUB;
        end else begin
          unknown = 1'b1;
        end
      end
      OP_ORI: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.alu_fn   = ALU_OR;
        ctrl.reg_wr   = 1'b1;
      end
      OP_LW: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.imm_signed  = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_wr      = 1'b1;
      end
      OP_SW: begin
        ctrl.b_is_imm   = 1'b1;
        ctrl.imm_signed = 1'b1;
        ctrl.mem_wr     = 1'b1;
      end
      OP_BEQ: begin
        ctrl.imm_signed = 1'b1;
        ctrl.alu_fn     = ALU_SUB;
        ctrl.branch     = 1'b1;
      end
      OP_JMP: begin
        ctrl.jump = 1'b1;
      end
      default: unknown = 1'b1;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG  = 32,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [AW-1:0]    ra,
  input  logic [AW-1:0]    rb,
  input  logic [AW-1:0]    rc,
  output logic [WIDTH-1:0] qa,
  output logic [WIDTH-1:0] qb,
  output logic [WIDTH-1:0] qc
);

  logic [WIDTH-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];
  assign qc = (rc == '0) ? '0 : regs[rc];

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
  parameter int WORDS = 64,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    idx,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] rd
);

  logic [WIDTH-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wd;
  end

  assign rd = cells[idx];

endmodule

// File: rtl/sc_fetch.sv
module sc_fetch
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  localparam int IA_W      = $clog2(IMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [IA_W-1:0] prog_addr,
  input  logic [31:0]     prog_data,
  input  logic            take_branch,
  input  logic            take_jump,
  input  logic [XLEN-1:0] imm_wide,
  input  logic [25:0]     jtarget,
  output logic [XLEN-1:0] pc_q,
  output logic [31:0]     instr
);

  logic [31:0]     rom [IMEM_WORDS];
  logic [XLEN-1:0] pc_seq;
  logic [XLEN-1:0] pc_nxt;

  always_ff @(posedge clk) begin
    if (prog_we) rom[prog_addr] <= prog_data;
  end

  assign instr  = rom[pc_q[IA_W+1:2]];
  assign pc_seq = pc_q + XLEN'(4);

  always_comb begin
    if (take_jump)        pc_nxt = jump_dest(pc_seq, jtarget);
    else if (take_branch) pc_nxt = branch_dest(pc_seq, imm_wide);
    else                  pc_nxt = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nxt;
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W      = $clog2(IMEM_WORDS),
  localparam int DA_W      = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [IA_W-1:0] prog_addr,
  input  logic [31:0]     prog_data,
  input  logic [4:0]      dbg_sel,
  output logic [31:0]     dbg_data,
  output logic [31:0]     pc
);

  logic [31:0]     instr;
  logic [XLEN-1:0] pc_q;
  ctrl_t           ctrl;
  logic            op_unknown;

  logic [4:0]      f_rs, f_rt, f_rd;
  logic [15:0]     f_imm;
  logic [XLEN-1:0] bus_a, bus_b, bus_w;
  logic [XLEN-1:0] imm_wide, alu_b, alu_y, mem_q;
  logic [4:0]      wr_reg;
  logic            rf_we, dm_we, br_take, jmp_take, operands_equal;

  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];

  sc_fetch #(.IMEM_WORDS(IMEM_WORDS)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_we    (prog_we),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .take_branch(br_take),
    .take_jump  (jmp_take),
    .imm_wide   (imm_wide),
    .jtarget    (instr[25:0]),
    .pc_q       (pc_q),
    .instr      (instr)
  );

  sc_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl),
    .unknown(op_unknown)
  );

  assign wr_reg = ctrl.dst_is_rd ? f_rd : f_rt;
  assign rf_we  = ctrl.reg_wr & rst_n;
  assign dm_we  = ctrl.mem_wr & rst_n;

  sc_regfile #(.NREG(32), .WIDTH(XLEN)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (rf_we),
    .wa   (wr_reg),
    .wd   (bus_w),
    .ra   (f_rs),
    .rb   (f_rt),
    .rc   (dbg_sel),
    .qa   (bus_a),
    .qb   (bus_b),
    .qc   (dbg_data)
  );

  assign imm_wide = widen_imm(f_imm, ctrl.imm_signed);
  assign alu_b    = ctrl.b_is_imm ? imm_wide : bus_b;
  assign alu_y    = alu_calc(ctrl.alu_fn, bus_a, alu_b);

  assign operands_equal = (alu_y == '0);
  assign br_take        = ctrl.branch & operands_equal & rst_n;
  assign jmp_take       = ctrl.jump & rst_n;

  sc_dmem #(.WORDS(DMEM_WORDS), .WIDTH(XLEN)) u_dm (
    .clk(clk),
    .we (dm_we),
    .idx(alu_y[DA_W+1:2]),
    .wd (bus_b),
    .rd (mem_q)
  );

  assign bus_w = ctrl.wb_from_mem ? mem_q : alu_y;
  assign pc    = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [4:0]  rs,
  input logic [31:0] bus_a,
  input logic [31:0] imm_wide,
  input logic        op_unknown,
  input logic        rf_we,
  input logic        dm_we,
  input logic        br_take,
  input logic        jmp_take
);

  // R1
  reset_pc_chk: assert property (@(posedge clk) !rst_n |=> pc == 32'd0);

  // R10
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_take && !jmp_take) |=> pc == $past(pc) + 32'd4);

  // R5
  branch_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> pc == $past(pc) + 32'd4 + ($past(imm_wide) << 2));

  // R6
  jump_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_take |=> (pc[1:0] == 2'b00) && ((pc >> 28) == (($past(pc) + 32'd4) >> 28)));

  // R7
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == 5'd0) |-> bus_a == 32'd0);

  // R8
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_unknown |-> (!rf_we && !dm_we));

  // R4
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> !rf_we);

endmodule

bind sc_core sc_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pc        (pc_q),
  .rs        (f_rs),
  .bus_a     (bus_a),
  .imm_wide  (imm_wide),
  .op_unknown(op_unknown),
  .rf_we     (rf_we),
  .dm_we     (dm_we),
  .br_take   (br_take),
  .jmp_take  (jmp_take)
);

// File: tb/sc_core_test.sv
module sc_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_data;
  logic [31:0] pc;

  int checks = 0;
  int fails  = 0;

  logic [31:0] image [64];
  int          n_words = 0;
  logic [31:0] trace [64];
  int          n_trace = 0;

  sc_core uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_we  (prog_we),
    .prog_addr(prog_addr),
    .prog_data(prog_data),
    .dbg_sel  (dbg_sel),
    .dbg_data (dbg_data),
    .pc       (pc)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic emit(logic [31:0] w, bit runs);
    image[n_words] = w;
    if (runs) begin
      trace[n_trace] = 32'(n_words * 4);
      n_trace++;
    end
    n_words++;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_check(string req, int r, logic [31:0] exp);
    dbg_sel = 5'(r);
    #1;
    check(req, dbg_data, exp);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v1, v2, v3, v6;
    v1 = 32'h0000FFFF;
    v2 = 32'h00008001;
    v3 = v2 | 32'h00001234;
    v6 = 32'd0 - v1;

    emit(enc_i(6'h0D, 0, 1, 16'hFFFF), 1);       // 0  ori r1
    emit(enc_i(6'h0D, 0, 2, 16'h8001), 1);       // 1  ori r2
    emit(enc_i(6'h0D, 2, 3, 16'h1234), 1);       // 2  ori r3 = r2|imm
    emit(enc_r(1, 2, 4, 6'h21), 1);              // 3  addu r4
    emit(enc_r(2, 1, 5, 6'h23), 1);              // 4  subu r5
    emit(enc_r(0, 1, 6, 6'h23), 1);              // 5  subu r6 wraps
    emit(enc_r(6, 6, 7, 6'h21), 1);              // 6  addu r7 wraps
    emit(enc_r(1, 1, 0, 6'h21), 1);              // 7  write to r0
    emit(enc_i(6'h3F, 1, 10, 16'h0001), 1);      // 8  unknown opcode
    emit(enc_r(1, 1, 11, 6'h20), 1);             // 9  unknown function
    emit(enc_i(6'h2B, 0, 2, 16'h0004), 1);       // 10 sw r2 -> word 1
    emit(enc_i(6'h23, 0, 12, 16'h0004), 1);      // 11 lw r12
    emit(enc_i(6'h0D, 0, 13, 16'h0020), 1);      // 12 ori r13 = 0x20
    emit(enc_i(6'h2B, 13, 3, 16'hFFF8), 1);      // 13 sw r3 -> 0x18
    emit(enc_i(6'h23, 0, 14, 16'h0018), 1);      // 14 lw r14
    emit(enc_i(6'h23, 0, 15, 16'h0118), 1);      // 15 lw r15, aliases word 6
    emit(enc_i(6'h04, 1, 2, 16'h0003), 1);       // 16 beq not taken
    emit(enc_i(6'h04, 3, 14, 16'h0001), 1);      // 17 beq taken -> 19
    emit(enc_i(6'h0D, 0, 17, 16'hDEAD), 0);      // 18 skipped
    emit({6'h02, 26'd22}, 1);                    // 19 j 22
    emit(enc_i(6'h0D, 0, 17, 16'hBEEF), 0);      // 20 skipped
    emit(enc_i(6'h0D, 0, 17, 16'hCAFE), 0);      // 21 skipped
    emit(enc_i(6'h0D, 0, 18, 16'h0055), 1);      // 22 ori r18
    emit(enc_i(6'h04, 0, 0, 16'hFFFF), 1);       // 23 self loop

    for (int i = 0; i < n_words; i++) begin
      @(negedge clk);
      prog_we   = 1'b1;
      prog_addr = 6'(i);
      prog_data = image[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    @(negedge clk);
    // R1: PC held at zero under reset
    check("R1 pc in reset", pc, 32'd0);
    reg_check("R1 reg in reset", 9, 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < n_trace; k++) begin
      #1;
      // R10 sequential, R5 branch at index 17/23, R6 jump at index 19
      check((k > 0 && trace[k-1] == 32'd68) ? "R5 taken branch" :
            (k > 0 && trace[k-1] == 32'd76) ? "R6 jump" :
            (k > 0 && trace[k-1] == 32'd64) ? "R5 untaken branch" : "R10 pc step",
            pc, trace[k]);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    #1;
    check("R5 backward self loop", pc, 32'd92);

    reg_check("R3 ori zero extend", 1, v1);
    reg_check("R3 ori low", 2, v2);
    reg_check("R3 ori with rs", 3, v3);
    reg_check("R2 addu", 4, v1 + v2);
    reg_check("R2 subu", 5, v2 - v1);
    reg_check("R2 subu wrap", 6, v6);
    reg_check("R2 addu wrap", 7, v6 + v6);
    reg_check("R7 r0 stays zero", 0, 32'd0);
    reg_check("R8 unknown opcode", 10, 32'd0);
    reg_check("R8 unknown function", 11, 32'd0);
    reg_check("R9 load after store", 12, v2);
    reg_check("R4 negative offset store", 14, v3);
    reg_check("R4 address index bits", 15, v3);
    reg_check("R5 skipped instruction", 17, 32'd0);
    reg_check("R6 jump landing", 18, 32'h55);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 pc after reset", pc, 32'd0);
    reg_check("R1 reg after reset", 4, 32'd0);
    summary();
  end

endmodule